// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Write Modes

This block is a synchronous memory with two fully independent access ports, A and B. The ports share one clock and the storage array and nothing else. Each port has an enable, a write enable, an address, a write-data bus and a registered read-data bus, so a port can present read data in the same cycle in which it writes.

A parameter on each port chooses what that port's read output shows after a cycle in which it writes. Write-first shows the word just written. Read-first shows the word the location held before the overwrite. No-change keeps the previous output. The two ports may use different modes.

When both ports reach the same location in one cycle, a fixed collision rule applies. If both write, port A's data is kept. If one writes and the other reads, the reader sees the old word. Read latency is one clock in every mode. Reset clears both read outputs but leaves the stored contents untouched.

Top module: `dpram_wm`

## Requirements
- R1: While `rstN` is low both read outputs are zero. Reset does not alter stored words, so a word written before reset reads back unchanged after it.
- R2: In a cycle where a port's enable is low, that port's read output keeps its previous value.
- R3: A write enable asserted while the port's enable is low stores nothing.
- R4: A read (enable high, write enable low) presents the word stored at the address on the read output one clock edge later, including a word written in the previous cycle.
- R5: Mode value 0 (write-first): after a write, that port's output shows the data the port itself wrote.
- R6: Mode value 1 (read-first): after a write, that port's output shows the word the address held before the write.
- R7: Mode value 2 (no-change): after a write, that port's output keeps its previous value.
- R8: If both ports write the same address in one cycle, port A's data is stored.
- R9: If one port writes an address while the other reads the same address, the reader gets the word stored before the write.
- R10: Each port's mode is set on its own. A mode value other than 0, 1 or 2 behaves as write-first.
- R11: Writes by both ports to different addresses in one cycle are both stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the read outputs |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable, used only with `enA` high |
| addrA | input | AW | Port A address |
| dinA | input | DW | Port A write data |
| doutA | output | DW | Port A registered read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable, used only with `enB` high |
| addrB | input | AW | Port B address |
| dinB | input | DW | Port B write data |
| doutB | output | DW | Port B registered read data |

## Verification
The bench targets same-address collisions. A design that let port B win a double write would read back B's data. A design that forwarded new data to the reading port would show the written word instead of the old one. All ten mode pairs (the nine legal pairs plus an illegal value on both ports) run side by side under the same stimulus. A mode decoder that mixed up read-first and no-change, or left an illegal value undefined, would then differ from the reference on exactly those instances. Directed steps cover a write asserted under a low enable, which a careless design would store, and a reset in mid-run, which would expose a design that clears memory contents or leaves stale read data.

// File: rtl/dpram_wm_pkg.sv
package dpram_wm_pkg;

  // Per-port write behaviour of the read output; values match the mode parameter.
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  // Strobes from control to datapath, one set per port.
  typedef struct packed {
    logic memWr;     // commit write data to the array
    logic outLoad;   // update the read register this cycle
    logic outSelWr;  // read register takes write data instead of array word
  } strobe_t;

  // Any value outside the legal set selects write-first.
  function automatic wmode_e normMode(int m);
    case (m)
      1:       return WM_READ_FIRST;
      2:       return WM_NO_CHANGE;
      default: return WM_WRITE_FIRST;
    endcase
  endfunction

endpackage

// File: rtl/dpram_wm_ctrl.sv
module dpram_wm_ctrl
  import dpram_wm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0
) (
  input  logic          en     [2],
  input  logic          we     [2],
  input  logic [AW-1:0] addr   [2],
  output strobe_t       strobe [2]
);

  logic wantWr [2];
  logic sameAddr;

  assign sameAddr = (addr[0] == addr[1]);

  for (genvar p = 0; p < 2; p++) begin : gPort
    localparam wmode_e PMODE = (p == 0) ? normMode(MODE_A) : normMode(MODE_B);

    assign wantWr[p] = en[p] & we[p];

    if (PMODE == WM_NO_CHANGE) begin : gNoChange
      assign strobe[p].outLoad  = en[p] & ~we[p];
      assign strobe[p].outSelWr = 1'b0;
    end else if (PMODE == WM_READ_FIRST) begin : gReadFirst
      assign strobe[p].outLoad  = en[p];
      assign strobe[p].outSelWr = 1'b0;
    end else begin : gWriteFirst
      assign strobe[p].outLoad  = en[p];
      assign strobe[p].outSelWr = we[p];
    end
  end

  // Port A has priority on a shared write address (R8).
  assign strobe[0].memWr = wantWr[0];
  assign strobe[1].memWr = wantWr[1] & ~(wantWr[0] & sameAddr);

endmodule

// File: rtl/dpram_wm_dp.sv
module dpram_wm_dp
  import dpram_wm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe [2],
  input  logic [AW-1:0] addr   [2],
  input  logic [DW-1:0] din    [2],
  output logic [DW-1:0] dout   [2]
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Array reads in the output registers see the pre-edge contents (R6, R9).
  always_ff @(posedge clk) begin
    if (strobe[1].memWr) store[addr[1]] <= din[1];
    if (strobe[0].memWr) store[addr[0]] <= din[0];
  end

  for (genvar p = 0; p < 2; p++) begin : gOut
    logic [DW-1:0] outReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg <= '0;
      end else if (strobe[p].outLoad) begin
        outReg <= strobe[p].outSelWr ? din[p] : store[addr[p]];
      end
    end

    assign dout[p] = outReg;
  end

endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
  import dpram_wm_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enA,
  input  logic          weA,
  input  logic [AW-1:0] addrA,
  input  logic [DW-1:0] dinA,
  output logic [DW-1:0] doutA,
  input  logic          enB,
  input  logic          weB,
  input  logic [AW-1:0] addrB,
  input  logic [DW-1:0] dinB,
  output logic [DW-1:0] doutB
);

  logic          en     [2];
  logic          we     [2];
  logic [AW-1:0] addr   [2];
  logic [DW-1:0] din    [2];
  logic [DW-1:0] dout   [2];
  strobe_t       strobe [2];

  assign en[0]   = enA;
  assign en[1]   = enB;
  assign we[0]   = weA;
  assign we[1]   = weB;
  assign addr[0] = addrA;
  assign addr[1] = addrB;
  assign din[0]  = dinA;
  assign din[1]  = dinB;
  assign doutA   = dout[0];
  assign doutB   = dout[1];

  dpram_wm_ctrl #(
    .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B)
  ) ctrl_i (
    .en(en), .we(we), .addr(addr), .strobe(strobe)
  );

  dpram_wm_dp #(
    .DW(DW), .AW(AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addr(addr), .din(din), .dout(dout)
  );

endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
  import dpram_wm_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0
) (
  input logic          clk,
  input logic          rstN,
  input logic          enA,
  input logic          weA,
  input logic [AW-1:0] addrA,
  input logic [DW-1:0] dinA,
  input logic [DW-1:0] doutA,
  input logic          enB,
  input logic          weB,
  input logic [AW-1:0] addrB,
  input logic [DW-1:0] dinB,
  input logic [DW-1:0] doutB,
  input logic          wrGrantB
);

  localparam wmode_e MA = normMode(MODE_A);
  localparam wmode_e MB = normMode(MODE_B);

  AST_IDLE_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !enA |=> $stable(doutA)); // R2
  AST_IDLE_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !enB |=> $stable(doutB)); // R2

  AST_SAME_ADDR_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (enA && weA && enB && weB && addrA == addrB) |-> !wrGrantB); // R8

  AST_READBACK_A: assert property (@(posedge clk) disable iff (!rstN)
    (enA && weA) ##1 (enA && !weA && addrA == $past(addrA))
    |=> doutA == $past(dinA, 2)); // R4
  AST_READBACK_B: assert property (@(posedge clk) disable iff (!rstN)
    (enB && weB && !(enA && weA && addrA == addrB)) ##1 (enB && !weB && addrB == $past(addrB))
    |=> doutB == $past(dinB, 2)); // R4

  if (MA == WM_WRITE_FIRST) begin : gWfA
    AST_WF_SHOWS_NEW: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA) |=> doutA == $past(dinA)); // R5
  end else if (MA == WM_NO_CHANGE) begin : gNcA
    AST_NC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (enA && weA) |=> $stable(doutA)); // R7
  end

  if (MB == WM_WRITE_FIRST) begin : gWfB
    AST_WF_SHOWS_NEW: assert property (@(posedge clk) disable iff (!rstN)
      (enB && weB) |=> doutB == $past(dinB)); // R5
  end else if (MB == WM_NO_CHANGE) begin : gNcB
    AST_NC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (enB && weB) |=> $stable(doutB)); // R7
  end

endmodule

bind dpram_wm dpram_wm_chk #(
  .DW(DW), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B)
) chk_i (
  .clk(clk), .rstN(rstN),
  .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA), .doutA(doutA),
  .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB), .doutB(doutB),
  .wrGrantB(strobe[1].memWr)
);

// File: tb/dpram_wm_tb_top.sv
module dpram_wm_tb_top;

  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int NINST = 10;
  localparam int DEPTH = 1 << AW;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          enA = 0, weA = 0, enB = 0, weB = 0;
  logic [AW-1:0] addrA = '0, addrB = '0;
  logic [DW-1:0] dinA = '0, dinB = '0;
  logic [DW-1:0] doutA [NINST];
  logic [DW-1:0] doutB [NINST];

  // Instance g: port A mode g/3, port B mode g%3; instance 9 uses illegal mode 3 on both.
  function automatic int modeOfA(int k); return (k < 9) ? k / 3 : 3; endfunction
  function automatic int modeOfB(int k); return (k < 9) ? k % 3 : 3; endfunction

  for (genvar g = 0; g < NINST; g++) begin : gMode
    dpram_wm #(
      .DW(DW), .AW(AW), .MODE_A(modeOfA(g)), .MODE_B(modeOfB(g))
    ) dut_i (
      .clk(clk), .rstN(rstN),
      .enA(enA), .weA(weA), .addrA(addrA), .dinA(dinA), .doutA(doutA[g]),
      .enB(enB), .weB(weB), .addrB(addrB), .dinB(dinB), .doutB(doutB[g])
    );
  end

  // ---------------- reference model ----------------
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] expA [NINST];
  logic [DW-1:0] expB [NINST];
  string         tagA [NINST];
  string         tagB [NINST];

  function automatic logic [DW-1:0] portNext(logic en, logic we, int mode,
      logic [DW-1:0] wdata, logic [DW-1:0] oldWord, logic [DW-1:0] cur);
    int m = (mode > 2) ? 0 : mode;
    if (!en) return cur;                 // R2
    if (!we) return oldWord;             // R4, R9
    if (m == 0) return wdata;            // R5, R10
    if (m == 1) return oldWord;          // R6
    return cur;                          // R7
  endfunction

  function automatic string portTag(logic en, logic we, int mode, logic otherWrSame);
    if (!en) return "R2";
    if (!we) return otherWrSame ? "R9" : "R4";
    if (mode > 2) return "R10";
    if (mode == 0) return "R5";
    if (mode == 1) return "R6";
    return "R7";
  endfunction

  initial for (int i = 0; i < DEPTH; i++) refMem[i] = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NINST; k++) begin
        expA[k] = '0; expB[k] = '0; tagA[k] = "R1"; tagB[k] = "R1";
      end
    end else begin
      logic [DW-1:0] oldA, oldB;
      oldA = refMem[addrA];
      oldB = refMem[addrB];
      for (int k = 0; k < NINST; k++) begin
        expA[k] = portNext(enA, weA, modeOfA(k), dinA, oldA, expA[k]);
        expB[k] = portNext(enB, weB, modeOfB(k), dinB, oldB, expB[k]);
        tagA[k] = portTag(enA, weA, modeOfA(k), enB && weB && addrB == addrA);
        tagB[k] = portTag(enB, weB, modeOfB(k), enA && weA && addrA == addrB);
      end
      if (enB && weB) refMem[addrB] = dinB;
      if (enA && weA) refMem[addrA] = dinA;   // R8: A wins
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit cmpOn   = 0;
  int cmpRun  = 0;
  int cmpFail = 0;

  always @(negedge clk) begin
    if (cmpOn) begin
      for (int k = 0; k < NINST; k++) begin
        cmpRun += 2;
        if (doutA[k] !== expA[k]) begin
          cmpFail++;
          $display("FAIL %s inst %0d port A: got %h expected %h", tagA[k], k, doutA[k], expA[k]);
        end
        if (doutB[k] !== expB[k]) begin
          cmpFail++;
          $display("FAIL %s inst %0d port B: got %h expected %h", tagB[k], k, doutB[k], expB[k]);
        end
      end
    end
  end

  // ---------------- directed checks ----------------
  int dirRun  = 0;
  int dirFail = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    dirRun++;
    if (act !== exp) begin
      dirFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic ea, logic wa, logic [AW-1:0] aa, logic [DW-1:0] da,
                       logic eb, logic wb, logic [AW-1:0] ab, logic [DW-1:0] db);
    @(negedge clk);
    enA = ea; weA = wa; addrA = aa; dinA = da;
    enB = eb; weB = wb; addrB = ab; dinB = db;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] initVal(int a);
    logic [7:0] b = a[7:0];
    return {b, ~b};
  endfunction

  typedef struct packed {
    logic        enA, weA; logic [7:0] addrA; logic [15:0] dinA;
    logic        enB, weB; logic [7:0] addrB; logic [15:0] dinB;
    logic        chkA; logic [15:0] expA;
    logic        chkB; logic [15:0] expB;
    logic [3:0]  req;
  } vec_t;

  // Checked on instance 0 one edge after each row.
  localparam vec_t VECS [10] = '{
    '{1,1,8'd10,16'h1111, 1,1,8'd20,16'h2222, 0,16'h0000, 0,16'h0000, 4'd11}, // R11 writes
    '{1,0,8'd10,16'h0000, 1,0,8'd20,16'h0000, 1,16'h1111, 1,16'h2222, 4'd11}, // R11 readback
    '{1,1,8'd30,16'hAAAA, 1,1,8'd30,16'hBBBB, 0,16'h0000, 0,16'h0000, 4'd8},  // R8 double write
    '{1,0,8'd30,16'h0000, 1,0,8'd30,16'h0000, 1,16'hAAAA, 1,16'hAAAA, 4'd8},  // R8 A kept
    '{1,1,8'd10,16'h3333, 1,0,8'd10,16'h0000, 0,16'h0000, 1,16'h1111, 4'd9},  // R9 B reads old
    '{1,0,8'd20,16'h0000, 1,1,8'd20,16'h4444, 1,16'h2222, 0,16'h0000, 4'd9},  // R9 A reads old
    '{0,1,8'd10,16'h5555, 0,1,8'd20,16'h6666, 1,16'h2222, 0,16'h0000, 4'd2},  // R3 stimulus, R2 hold
    '{1,0,8'd10,16'h0000, 1,0,8'd20,16'h0000, 1,16'h3333, 1,16'h4444, 4'd3},  // R3 nothing stored
    '{1,0,8'd40,16'h0000, 1,0,8'd41,16'h0000, 1,16'h28D7, 1,16'h29D6, 4'd4},  // R4 plain read
    '{0,0,8'd99,16'h0000, 0,0,8'd98,16'h0000, 1,16'h28D7, 1,16'h29D6, 4'd2}   // R2 hold
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick;
    check("R1", doutA[0], '0, "port A after reset");
    check("R1", doutB[0], '0, "port B after reset");

    // fill the array
    for (int i = 0; i < DEPTH / 2; i++)
      drive(1, 1, AW'(i), initVal(i), 1, 1, AW'(i + DEPTH / 2), initVal(i + DEPTH / 2));
    drive(1, 0, '0, '0, 1, 0, AW'(1), '0);
    tick;
    cmpOn = 1;

    // table walk
    foreach (VECS[r]) begin
      drive(VECS[r].enA, VECS[r].weA, VECS[r].addrA, VECS[r].dinA,
            VECS[r].enB, VECS[r].weB, VECS[r].addrB, VECS[r].dinB);
      tick;
      if (VECS[r].chkA) check($sformatf("R%0d", VECS[r].req), doutA[0], VECS[r].expA, $sformatf("row %0d port A", r));
      if (VECS[r].chkB) check($sformatf("R%0d", VECS[r].req), doutB[0], VECS[r].expB, $sformatf("row %0d port B", r));
    end

    // per-mode write response on port A
    drive(1, 0, 8'd61, '0, 0, 0, '0, '0);
    tick;
    drive(1, 1, 8'd60, 16'h1234, 0, 0, '0, '0);
    tick;
    check("R5",  doutA[0], 16'h1234,     "write-first shows new word");
    check("R6",  doutA[3], initVal(60),  "read-first shows old word");
    check("R7",  doutA[6], initVal(61),  "no-change keeps prior read");
    check("R10", doutA[9], 16'h1234,     "illegal mode acts write-first");
    check("R10", doutB[3], doutB[0],     "port B unaffected by port A mode");

    // random traffic on a narrow address range to force collisions
    for (int n = 0; n < 3000; n++)
      drive(($urandom % 4) != 0, $urandom % 2, AW'($urandom % 8), DW'($urandom),
            ($urandom % 4) != 0, $urandom % 2, AW'($urandom % 8), DW'($urandom));

    // R1: reset clears outputs, keeps contents
    drive(1, 1, 8'd5, 16'hBEEF, 0, 0, '0, '0);
    tick;
    @(negedge clk);
    enA = 0; enB = 0; rstN = 1'b0;
    tick;
    check("R1", doutA[0], '0, "port A during reset");
    check("R1", doutB[4], '0, "port B during reset");
    @(negedge clk);
    rstN = 1'b1;
    drive(1, 0, 8'd5, '0, 0, 0, '0, '0);
    tick;
    check("R1", doutA[0], 16'hBEEF, "contents survive reset");

    drive(0, 0, '0, '0, 0, 0, '0, '0);
    tick;
    $display("  [TB] %0d tests run, %0d failed", cmpRun + dirRun, cmpFail + dirFail);
    $finish;
  end

  initial begin
    #800000;
    dirRun++;
    dirFail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", cmpRun + dirRun, cmpFail + dirFail);
    $finish;
  end

endmodule